// File: doc/BRIEF.md
# Temperature Alarm Event Controller

This block watches a stream of digital temperature samples and drives an active-low, open-drain style event line. Three limits are set through a small write-only register port: a lower and an upper bound that form an alarm window, and a critical trip point. Every limit compare applies a selectable hysteresis. A compare asserts when the sample moves past the limit. It releases only when the sample has moved back past the limit by the hysteresis amount.

Three reporting modes are provided. In interrupt mode a fresh entry into a window alarm is latched, and the latch holds until software writes a clear strobe. In compare mode the line follows the alarm state, and the clear strobe does nothing. In critical-only mode the window is ignored and only the critical trip point matters. In every mode an active critical condition holds the line low as a comparator, and a clear cannot release it. An enable bit can keep the line released at all times. The internal state keeps running while the line is held.

Top module: `tae_event_ctrl`

## Requirements
- R1: After reset the configuration is all zero (output disabled, window disabled, interrupt mode, no hysteresis), the lower limit is the most negative value, the upper and critical limits are the most positive value, no alarm is active, and `event_n` is 1.
- R2: While configuration bit 0 (output enable) is 0, `event_n` is 1 whatever the alarm state. The alarm state keeps tracking samples, so setting the bit again shows the current state on the next cycle.
- R3: Register port: address 0 is configuration, where bit 0 is the output enable, bit 1 is the window enable, bits [3:2] are the mode (00 interrupt, 01 compare, 10 or 11 critical-only), bits [5:4] are the hysteresis code, and bit 6 is a clear strobe that is not stored. Address 1 is the lower limit, address 2 the upper limit and address 3 the critical limit. All limits and samples are 11-bit two's complement at 0.25 °C per LSB. A write takes effect at the clock edge that accepts it. A sample in that same cycle is judged against the old values, and `event_n` changes one cycle after the accepting edge.
- R4: When the window is enabled and the mode is not critical-only, a sample above the upper limit sets the high alarm and a sample below the lower limit sets the low alarm. Otherwise each sample clears both. Alarm states change only on cycles with `samp_valid` high.
- R5: Hysteresis H is 0, 6, 12 or 24 LSB (0, 1.5, 3 or 6 °C) for codes 0 to 3. An active high alarm releases on a sample at or below upper−H. An active low alarm releases on a sample at or above lower+H. The critical state releases on a sample at or below critical−H.
- R6: In compare mode, with output enabled, `event_n` is 0 exactly while the high, low or critical state is active, and the clear strobe has no effect.
- R7: In interrupt mode a sample that turns a window alarm from inactive to active sets the latch. The latch drives `event_n` low until a clear strobe. Samples that stay outside the window do not set it again.
- R8: When a clear strobe and a latching window entry fall in the same cycle, the entry wins and the latch stays set.
- R9: A sample above the critical limit sets the critical state in every mode. While it is active and output is enabled, `event_n` is 0, and clear strobes do not release it.
- R10: In critical-only mode, samples outside the window never drive `event_n` low. Only the critical state does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | A new temperature sample is present |
| samp_temp | input | 11 | Signed temperature sample, 0.25 °C per LSB |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 11 | Register write data |
| event_n | output | 1 | Active-low event line, 1 when released |

## Verification
Three pairs of functions can land in the same cycle. The first is a clear strobe together with a sample that enters the window alarm in interrupt mode. The bench provokes it by driving a configuration write with bit 6 set in the same cycle as a sample above the upper limit, and the line must stay low (the entry wins). The second is a limit write together with a sample: a critical limit raised in the very cycle of a hot sample must not yet release the critical state, and the next sample must. The third comes from the random phase, which overlaps writes, clears and samples freely and compares the line on every clock against a behavioural model that uses the same old-value rule.

// File: rtl/tae_pkg.sv
package tae_pkg;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'b00,
        MODE_LEVEL = 2'b01,
        MODE_CRIT  = 2'b10,
        MODE_CRITX = 2'b11
    } mode_e;

    typedef struct packed {
        logic       out_en;
        logic       win_en;
        mode_e      mode;
        logic [1:0] hyst;
    } cfg_t;

    localparam logic [1:0] ADR_CFG  = 2'd0;
    localparam logic [1:0] ADR_LOW  = 2'd1;
    localparam logic [1:0] ADR_HIGH = 2'd2;
    localparam logic [1:0] ADR_CRIT = 2'd3;

    localparam int CLR_BIT = 6;

    function automatic logic is_crit_only(mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/tae_regs.sv
module tae_regs
    import tae_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [TW-1:0]        wdata,
    output cfg_t                 cfg,
    output logic signed [TW-1:0] lim_low,
    output logic signed [TW-1:0] lim_high,
    output logic signed [TW-1:0] lim_crit,
    output logic                 clr
);

    localparam logic signed [TW-1:0] SMIN = {1'b1, {(TW-1){1'b0}}};
    localparam logic signed [TW-1:0] SMAX = {1'b0, {(TW-1){1'b1}}};

    typedef struct packed {
        cfg_t                 cfg;
        logic signed [TW-1:0] lo;
        logic signed [TW-1:0] hi;
        logic signed [TW-1:0] cr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                ADR_CFG: begin
                    r_d.cfg.out_en = wdata[0];
                    r_d.cfg.win_en = wdata[1];
                    r_d.cfg.mode   = mode_e'(wdata[3:2]);
                    r_d.cfg.hyst   = wdata[5:4];
                end
                ADR_LOW:  r_d.lo = wdata;
                ADR_HIGH: r_d.hi = wdata;
                default:  r_d.cr = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg <= '0;
            r_q.lo  <= SMIN;
            r_q.hi  <= SMAX;
            r_q.cr  <= SMAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg      = r_q.cfg;
    assign lim_low  = r_q.lo;
    assign lim_high = r_q.hi;
    assign lim_crit = r_q.cr;
    assign clr      = we && (addr == ADR_CFG) && wdata[CLR_BIT];

    // R3: a limit write is visible on the following cycle
    a_r3_limit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_CRIT) |=> (lim_crit == $past(wdata)));

endmodule

// File: rtl/tae_limit_cmp.sv
module tae_limit_cmp #(
    parameter int TW    = 11,
    parameter int HW    = 5,
    parameter bit ABOVE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 enable,
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] limit,
    input  logic [HW-1:0]        hyst,
    output logic                 active,
    output logic                 rise
);

    localparam int EW = TW + 2;

    typedef struct packed {
        logic act;
    } cmp_t;

    cmp_t s_d, s_q;

    logic signed [EW-1:0] t_x, l_x, h_x, thr;
    logic                 hit;

    assign t_x = EW'(temp);
    assign l_x = EW'(limit);
    assign h_x = $signed({{(EW-HW){1'b0}}, hyst});

    always_comb begin
        s_d = s_q;
        if (ABOVE) begin
            thr = s_q.act ? (l_x - h_x) : l_x;
            hit = t_x > thr;
        end else begin
            thr = s_q.act ? (l_x + h_x) : l_x;
            hit = t_x < thr;
        end
        if (sample) begin
            s_d.act = enable && hit;
        end
        rise = sample && enable && hit && !s_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.act;

    // R4: state only moves on a sample
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(active));

    // R4: crossing the raw limit always sets the state
    a_r4_set_on_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && enable && (ABOVE ? (temp > limit) : (temp < limit))) |=> active);

    // R5: moving back past limit -/+ hysteresis releases it
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && active &&
         (ABOVE ? (t_x <= l_x - h_x) : (t_x >= l_x + h_x))) |=> !active);

endmodule

// File: rtl/tae_event_core.sv
module tae_event_core
    import tae_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cfg_t  cfg,
    input  logic  clr,
    input  logic  hi_act,
    input  logic  lo_act,
    input  logic  cr_act,
    input  logic  hi_rise,
    input  logic  lo_rise,
    output logic  event_n
);

    typedef struct packed {
        logic latch;
    } core_t;

    core_t c_d, c_q;
    logic  win_rise;
    logic  ev_low;

    assign win_rise = hi_rise || lo_rise;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.latch = 1'b0;
        end
        if (cfg.mode == MODE_LATCH && win_rise) begin
            c_d.latch = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        ev_low = cr_act;
        unique case (cfg.mode)
            MODE_LATCH: ev_low = ev_low || c_q.latch;
            MODE_LEVEL: ev_low = ev_low || hi_act || lo_act;
            default:    ev_low = ev_low;
        endcase
        event_n = !(cfg.out_en && ev_low);
    end

    // R7: the latch rises only on a fresh window entry
    a_r7_latch_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !win_rise |=> !$rose(c_q.latch));

    // R8: entry beats a clear in the same cycle
    a_r8_entry_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_LATCH && win_rise && clr) |=> c_q.latch);

    // R9: critical state forces the line low
    a_r9_crit_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.out_en && cr_act) |-> !event_n);

    // R6: level mode follows window state
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.out_en && cfg.mode == MODE_LEVEL && (hi_act || lo_act)) |-> !event_n);

endmodule

// File: rtl/tae_event_ctrl.sv
module tae_event_ctrl
    import tae_pkg::*;
#(
    parameter int TW        = 11,
    parameter int HYST_UNIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_valid,
    input  logic [TW-1:0] samp_temp,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [TW-1:0] cfg_wdata,
    output logic          event_n
);

    localparam int HW    = $clog2(4 * HYST_UNIT + 1);
    localparam int NCMP  = 3;
    localparam int I_HI  = 0;
    localparam int I_LO  = 1;
    localparam int I_CR  = 2;

    cfg_t                 cfg;
    logic signed [TW-1:0] lim_low, lim_high, lim_crit;
    logic                 clr;
    logic [HW-1:0]        hyst_lsb;
    logic                 win_on;

    logic signed [TW-1:0] lim_v [NCMP];
    logic                 en_v  [NCMP];
    logic                 act_v [NCMP];
    logic                 rise_v[NCMP];

    tae_regs #(.TW(TW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .lim_low  (lim_low),
        .lim_high (lim_high),
        .lim_crit (lim_crit),
        .clr      (clr)
    );

    always_comb begin
        unique case (cfg.hyst)
            2'd0:    hyst_lsb = '0;
            2'd1:    hyst_lsb = HW'(HYST_UNIT);
            2'd2:    hyst_lsb = HW'(2 * HYST_UNIT);
            default: hyst_lsb = HW'(4 * HYST_UNIT);
        endcase
    end

    assign win_on     = cfg.win_en && !is_crit_only(cfg.mode);
    assign lim_v[I_HI] = lim_high;
    assign lim_v[I_LO] = lim_low;
    assign lim_v[I_CR] = lim_crit;
    assign en_v[I_HI]  = win_on;
    assign en_v[I_LO]  = win_on;
    assign en_v[I_CR]  = 1'b1;

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        tae_limit_cmp #(
            .TW    (TW),
            .HW    (HW),
            .ABOVE (gi != I_LO)
        ) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (samp_valid),
            .enable (en_v[gi]),
            .temp   ($signed(samp_temp)),
            .limit  (lim_v[gi]),
            .hyst   (hyst_lsb),
            .active (act_v[gi]),
            .rise   (rise_v[gi])
        );
    end

    tae_event_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .clr     (clr),
        .hi_act  (act_v[I_HI]),
        .lo_act  (act_v[I_LO]),
        .cr_act  (act_v[I_CR]),
        .hi_rise (rise_v[I_HI]),
        .lo_rise (rise_v[I_LO]),
        .event_n (event_n)
    );

    // R2: writing output enable low releases the line next cycle
    a_r2_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADR_CFG && !cfg_wdata[0]) |=> event_n);

    // R10: in critical-only mode window states stay idle after a sample
    a_r10_window_off: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && is_crit_only(cfg.mode)) |=> (!act_v[I_HI] && !act_v[I_LO]));

endmodule

// File: tb/tae_event_ctrl_tb.sv
`timescale 1ns/100ps
module tae_event_ctrl_tb_top;

    localparam int TW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          samp_valid = 1'b0;
    logic [TW-1:0] samp_temp = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [TW-1:0] cfg_wdata = '0;
    logic          event_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tae_event_ctrl #(.TW(TW), .HYST_UNIT(6)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_valid (samp_valid),
        .samp_temp  (samp_temp),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .event_n    (event_n)
    );

    // ---------------- behavioural reference model ----------------
    int m_en, m_win, m_mode, m_hc;
    int m_lo, m_hi, m_cr;
    int s_hi, s_lo, s_cr, s_lat;

    function automatic int hyst_of(int code);
        case (code)
            0: return 0;
            1: return 6;
            2: return 12;
            default: return 24;
        endcase
    endfunction

    function automatic int m_event_n();
        int low;
        low = s_cr;
        if (m_mode == 0) low = low | s_lat;
        else if (m_mode == 1) low = low | s_hi | s_lo;
        return (m_en != 0 && low != 0) ? 0 : 1;
    endfunction

    function automatic string tag_of();
        if (m_en == 0) return "R2";
        if (s_cr != 0) return "R9";
        if (m_mode == 0) return "R7";
        if (m_mode == 1) return "R6";
        return "R10";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_win = 0; m_mode = 0; m_hc = 0;
            m_lo = -1024; m_hi = 1023; m_cr = 1023;
            s_hi = 0; s_lo = 0; s_cr = 0; s_lat = 0;
        end else begin
            int h, t, nh, nl, nc, ent, won, clr;
            h   = hyst_of(m_hc);
            won = (m_win != 0 && m_mode < 2);
            clr = (cfg_we && cfg_addr == 2'd0 && cfg_wdata[6]);
            nh = s_hi; nl = s_lo; nc = s_cr; ent = 0;
            if (samp_valid) begin
                t  = int'($signed(samp_temp));
                nh = won && (s_hi ? (t > m_hi - h) : (t > m_hi));
                nl = won && (s_lo ? (t < m_lo + h) : (t < m_lo));
                nc = s_cr ? (t > m_cr - h) : (t > m_cr);
                ent = (nh && !s_hi) || (nl && !s_lo);
            end
            if (clr) s_lat = 0;
            if (m_mode == 0 && ent) s_lat = 1;
            s_hi = nh; s_lo = nl; s_cr = nc;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin
                        m_en = cfg_wdata[0]; m_win = cfg_wdata[1];
                        m_mode = cfg_wdata[3:2]; m_hc = cfg_wdata[5:4];
                    end
                    2'd1: m_lo = int'($signed(cfg_wdata));
                    2'd2: m_hi = int'($signed(cfg_wdata));
                    default: m_cr = int'($signed(cfg_wdata));
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (event_n !== m_event_n()) begin
                bad++;
                $display("FAIL %s model compare: event_n=%0b expected=%0b at %0t",
                         tag_of(), event_n, m_event_n(), $time);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input bit we, input logic [1:0] a, input int d,
                        input bit sv, input int t);
        cfg_we     = we;
        cfg_addr   = a;
        cfg_wdata  = TW'(d);
        samp_valid = sv;
        samp_temp  = TW'(t);
        @(negedge clk);
        cfg_we     = 1'b0;
        samp_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        step(1'b1, a, d, 1'b0, 0);
    endtask

    task automatic smp(input int t);
        step(1'b0, 2'd0, 0, 1'b1, t);
    endtask

    task automatic chk(input string req, input logic exp);
        total++;
        if (event_n !== exp) begin
            bad++;
            $display("FAIL %s: event_n=%0b expected=%0b at %0t", req, event_n, exp, $time);
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // cfg = en | win<<1 | mode<<2 | hyst<<4 | clear<<6
    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 1'b1);
        smp(2000 - 2048 + 1000);
        chk("R1", 1'b1);

        wr(2'd1, -40); wr(2'd2, 200); wr(2'd3, 340);
        wr(2'd0, 'h17);                 // level mode, hyst 6
        smp(100);  chk("R6", 1'b1);
        smp(201);  chk("R4", 1'b0);
        smp(198);  chk("R5", 1'b0);
        smp(194);  chk("R5", 1'b1);
        smp(-41);  chk("R4", 1'b0);
        wr(2'd0, 'h57); chk("R6", 1'b0);
        smp(-35);  chk("R5", 1'b0);
        smp(-34);  chk("R5", 1'b1);

        wr(2'd0, 'h13);                 // latch mode, hyst 6
        smp(250);  chk("R7", 1'b0);
        smp(100);  chk("R7", 1'b0);
        wr(2'd0, 'h53); chk("R7", 1'b1);
        smp(250);  chk("R7", 1'b0);
        wr(2'd0, 'h53); chk("R7", 1'b1);
        smp(260);  chk("R7", 1'b1);
        smp(100);  chk("R7", 1'b1);
        step(1'b1, 2'd0, 'h53, 1'b1, 250); chk("R8", 1'b0);
        wr(2'd0, 'h53); smp(100); chk("R8", 1'b1);

        smp(341);  chk("R9", 1'b0);
        wr(2'd0, 'h53); chk("R9", 1'b0);
        smp(335);  chk("R9", 1'b0);
        smp(334);  chk("R9", 1'b1);

        wr(2'd0, 'h3B);                 // critical-only, hyst 24
        smp(100);  chk("R10", 1'b1);
        smp(250);  chk("R10", 1'b1);
        smp(-100); chk("R10", 1'b1);
        smp(341);  chk("R10", 1'b0);
        smp(320);  chk("R5", 1'b0);
        smp(316);  chk("R5", 1'b1);

        smp(400);  chk("R9", 1'b0);
        wr(2'd0, 'h3A); chk("R2", 1'b1);
        smp(450);  chk("R2", 1'b1);
        wr(2'd0, 'h3B); chk("R2", 1'b0);

        step(1'b1, 2'd3, 500, 1'b1, 400); chk("R3", 1'b0);
        smp(400);  chk("R3", 1'b1);

        for (int i = 0; i < 600; i++) begin
            int r, wdat;
            r = $urandom_range(0, 9);
            if (r < 2) begin
                wdat = 1 | ($urandom_range(0, 63) << 1);
                step(1'b1, 2'd0, wdat, $urandom_range(0, 1), $urandom_range(0, 500) - 100);
            end else if (r < 3) begin
                step(1'b1, 2'($urandom_range(1, 3)), $urandom_range(0, 500) - 100,
                     $urandom_range(0, 1), $urandom_range(0, 500) - 100);
            end else begin
                smp($urandom_range(0, 500) - 100);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule